// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

A five-stage twisted-ring counter that divides its clock by any whole number from 2 to 10. All stages advance together on the rising clock edge: the first stage takes a feedback bit and every later stage copies the stage ahead of it. The ratio input chooses where the feedback comes from. For even ratios it is a single stage output. For odd ratios it is the AND of two neighbouring stage outputs, which removes one state from the loop.

The stage outputs are inverted with respect to the stored state. An asynchronous clear drives every output to 1. An asynchronous load drives each output to the complement of its own load bit, and clear wins when both are raised. Anti-lock logic checks the stages that are inside the loop. If they hold a pattern the ring can never reach, the next edge sends the counter to the cleared state. From there it runs the normal sequence.

The divided clock is the output of the last stage in the loop. Stage k is in the loop when k ≤ L, where L = ceil(N/2).

Top module: `jdiv_counter`

## Requirements
- R1: While `clear` is 1, `stage_q` reads 5'b11111 and `div_clk` reads 1, without waiting for a clock edge.
- R2: While `load` is 1 and `clear` is 0, `stage_q` reads `~load_val`, without waiting for a clock edge, and clock edges do not change it.
- R3: When `clear` and `load` are both 1, clear wins and `stage_q` reads 5'b11111.
- R4: On every rising edge in normal counting, `stage_q[k]` takes the previous `stage_q[k-1]` for k = 1..4. `stage_q[0]` is stage 1.
- R5: For an even ratio N, the feedback is stage output N/2. Starting from clear, the loop stages return to all-ones after exactly N edges and not before.
- R6: For an odd ratio N, the feedback is the AND of stage outputs L and L-1, where L = (N+1)/2. The loop stages repeat after exactly N edges. Their outputs are never all 0.
- R7: `div_clk` always equals the output of stage L. It is high for ceil(N/2) of every N cycles.
- R8: A `ratio_sel` value outside 2..10 (0, 1 or 11..15) gives divide-by-10.
- R9: If the loop stages hold a pattern with more than one change between neighbouring stages, the next edge sets every output to 1. Stages outside the loop never trigger this.
- R10: When `load` is 0, changes on `load_val` have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge |
| clear | input | 1 | Asynchronous clear, active high; outputs go to all ones |
| load | input | 1 | Asynchronous load, active high |
| load_val | input | 5 | Load value; the outputs take its complement |
| ratio_sel | input | 4 | Division ratio N, 2..10 |
| stage_q | output | 5 | Inverted stage outputs, bit 0 = stage 1 |
| div_clk | output | 1 | Divided clock, output of stage L |

## Verification
A bad feedback tap or odd-mode gate shows up within one period of N edges. The loop stages then repeat early or late, or they reach all-zero outputs in an odd mode. A broken shift path shows up on the first edge, because one output no longer copies its neighbour. A faulty anti-lock check shows up one edge after an illegal pattern is loaded. Either the outputs fail to go to all ones, or a legal pattern is wrongly cleared. The ratio decode, including the out-of-range values, is checked through the period and the duty of `div_clk`.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } jdiv_parity_e;

  function automatic int jdiv_clip_ratio(input int r, input int stages);
    if (r < 2 || r > 2 * stages) return 2 * stages;
    return r;
  endfunction
endpackage

// File: rtl/jdiv_ratio_decode.sv
module jdiv_ratio_decode
  import jdiv_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] len_oh,
  output jdiv_parity_e      parity
);
  int eff_ratio;
  int loop_len;

  always_comb begin
    eff_ratio = jdiv_clip_ratio(int'(ratio_sel), STAGES);
    loop_len  = (eff_ratio + 1) / 2;
    parity    = (eff_ratio % 2 == 1) ? PAR_ODD : PAR_EVEN;
    for (int i = 0; i < STAGES; i++) begin
      len_oh[i] = (loop_len == i + 1);
    end
  end

  // exactly one stage is selected as the end of the loop
  always_comb begin
    assert_single_tap_R7: assert ($onehot(len_oh));
  end
endmodule

// File: rtl/jdiv_feedback.sv
module jdiv_feedback
  import jdiv_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] state,
  input  logic [STAGES-1:0] len_oh,
  input  jdiv_parity_e      parity,
  output logic              fb,
  output logic              illegal
);
  localparam int NPAIR = STAGES - 1;

  logic [STAGES-1:0] outs;
  logic [NPAIR-1:0]  edge_seen;
  logic [NPAIR-1:0]  pair_live;
  int                edge_cnt;

  assign outs = ~state;

  // feedback: last loop stage, or AND with its neighbour in odd mode
  always_comb begin
    fb = 1'b0;
    for (int i = 0; i < STAGES; i++) begin
      if (len_oh[i]) begin
        if (parity == PAR_ODD && i > 0) fb = outs[i] & outs[i-1];
        else                            fb = outs[i];
      end
    end
  end

  // a pair is inside the loop when the loop end lies beyond it
  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      assign edge_seen[g] = state[g] ^ state[g+1];
      assign pair_live[g] = |len_oh[STAGES-1:g+1];
    end
  endgenerate

  always_comb begin
    edge_cnt = 0;
    for (int i = 0; i < NPAIR; i++) begin
      if (edge_seen[i] && pair_live[i]) edge_cnt = edge_cnt + 1;
    end
    illegal = (edge_cnt > 1);
  end
endmodule

// File: rtl/jdiv_stage_chain.sv
module jdiv_stage_chain #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  input  logic              fb,
  input  logic              illegal,
  output logic [STAGES-1:0] state
);
  always_ff @(posedge clk or posedge clear or posedge load) begin
    if (clear)        state <= '0;
    else if (load)    state <= load_val;
    else if (illegal) state <= '0;
    else              state <= {state[STAGES-2:0], fb};
  end

  assert_shift_path_R4: assert property (@(posedge clk) disable iff (clear || load)
    !illegal |=> state[STAGES-1:1] == $past(state[STAGES-2:0]));

  assert_lock_clears_R9: assert property (@(posedge clk) disable iff (clear || load)
    illegal |=> state == '0);
endmodule

// File: rtl/jdiv_counter.sv
module jdiv_counter
  import jdiv_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] stage_q,
  output logic              div_clk
);
  logic [STAGES-1:0] state;
  logic [STAGES-1:0] len_oh;
  jdiv_parity_e      parity;
  logic              fb;
  logic              illegal;

  jdiv_ratio_decode #(.STAGES(STAGES), .SEL_W(SEL_W)) u_dec (
    .ratio_sel (ratio_sel),
    .len_oh    (len_oh),
    .parity    (parity)
  );

  jdiv_feedback #(.STAGES(STAGES)) u_fb (
    .state   (state),
    .len_oh  (len_oh),
    .parity  (parity),
    .fb      (fb),
    .illegal (illegal)
  );

  jdiv_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .clear    (clear),
    .load     (load),
    .load_val (load_val),
    .fb       (fb),
    .illegal  (illegal),
    .state    (state)
  );

  assign stage_q = ~state;
  assign div_clk = |(stage_q & len_oh);

  // once on the ring, the counter stays on it while the ratio holds
  assert_stays_legal_R5: assert property (@(posedge clk) disable iff (clear || load)
    !illegal |=> (!$stable(ratio_sel) || !illegal));
endmodule

// File: tb/jdiv_counter_test.sv
module jdiv_counter_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       load = 1'b0;
  logic [4:0] load_val = '0;
  logic [3:0] ratio_sel = 4'd10;
  logic [4:0] stage_q;
  logic       div_clk;

  int n_run = 0;
  int n_fail = 0;

  jdiv_counter uut (
    .clk(clk), .clear(clear), .load(load), .load_val(load_val),
    .ratio_sel(ratio_sel), .stage_q(stage_q), .div_clk(div_clk)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic restart(input logic [3:0] sel);
    ratio_sel = sel;
    clear = 1'b1;
    step();
    clear = 1'b0;
  endtask

  task automatic t_clear_async();
    restart(4'd10);
    step(); step();
    chk(stage_q == 5'b11100, "R4", stage_q, 5'b11100);
    clear = 1'b1;
    #1;
    chk(stage_q == 5'b11111, "R1", stage_q, 5'b11111);
    chk(div_clk == 1'b1, "R1", div_clk, 1);
    step();
    clear = 1'b0;
  endtask

  task automatic t_load_async();
    restart(4'd10);
    step();
    load_val = 5'b01101;
    load = 1'b1;
    #1;
    chk(stage_q == 5'b10010, "R2", stage_q, 5'b10010);
    step(); step();
    chk(stage_q == 5'b10010, "R2", stage_q, 5'b10010);
    load = 1'b0;
  endtask

  task automatic t_priority();
    load_val = 5'b00000;
    load = 1'b1;
    clear = 1'b1;
    #1;
    chk(stage_q == 5'b11111, "R3", stage_q, 5'b11111);
    step();
    chk(stage_q == 5'b11111, "R3", stage_q, 5'b11111);
    load = 1'b0;
    clear = 1'b0;
  endtask

  task automatic t_ratio(input int n, input logic [3:0] sel, input string req);
    int len = (n + 1) / 2;
    logic [4:0] mask = 5'((1 << len) - 1);
    logic [4:0] prev;
    int first = 0, hi = 0, zeros = 0, shift_bad = 0, tap_bad = 0;
    restart(sel);
    prev = stage_q;
    for (int c = 1; c <= 2 * n; c++) begin
      step();
      if (stage_q[4:1] != prev[3:0]) shift_bad++;
      if (c <= n) begin
        if (div_clk) hi++;
        if (div_clk != stage_q[len-1]) tap_bad++;
        if ((stage_q & mask) == 5'b0) zeros++;
      end
      if (first == 0 && (stage_q & mask) == mask) first = c;
      prev = stage_q;
    end
    chk(shift_bad == 0, "R4", shift_bad, 0);
    chk(first == n, req, first, n);
    chk(hi == len, "R7", hi, len);
    chk(tap_bad == 0, "R7", tap_bad, 0);
    if (n % 2 == 1) chk(zeros == 0, "R6", zeros, 0);
  endtask

  task automatic t_antilock();
    restart(4'd10);
    load_val = 5'b00101;
    load = 1'b1;
    step();
    load = 1'b0;
    step();
    chk(stage_q == 5'b11111, "R9", stage_q, 5'b11111);
    step();
    chk(stage_q == 5'b11110, "R9", stage_q, 5'b11110);
    restart(4'd4);
    load_val = 5'b10101;
    load = 1'b1;
    step();
    load = 1'b0;
    step();
    chk(stage_q == 5'b10100, "R9", stage_q, 5'b10100);
  endtask

  task automatic t_jam_ignored();
    restart(4'd10);
    for (int c = 0; c < 3; c++) begin
      load_val = 5'(7 * c + 9);
      step();
    end
    chk(stage_q == 5'b11000, "R10", stage_q, 5'b11000);
  endtask

  initial begin
    step();
    chk(stage_q == 5'b11111, "R1", stage_q, 5'b11111);
    t_clear_async();
    t_load_async();
    t_priority();
    for (int n = 2; n <= 10; n++) begin
      t_ratio(n, 4'(n), (n % 2 == 0) ? "R5" : "R6");
    end
    t_ratio(10, 4'd0, "R8");
    t_ratio(10, 4'd1, "R8");
    t_ratio(10, 4'd11, "R8");
    t_ratio(10, 4'd15, "R8");
    t_antilock();
    t_jam_ignored();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule